// File: doc/BRIEF.md
# Event-Branch Control Unit

This unit keeps the user-level event-branch state of a 64-bit core. It has three 64-bit registers: a status/control word, a return-address word and a handler-address word. Status bit numbers in this brief use the conventional LSB-0 numbering of the `reg_wr_data` and `reg_rd_data` vectors. When an event source asks for a branch and the unit permits it, the unit saves the address of the instruction that would have run next. It also clears the global enable, records which source fired, and sends fetch to the handler address one cycle later.

The unit also carries out the return-from-event-branch operation. It sends fetch back to the saved return address and writes the global enable from a one-bit operand. In 32-bit mode the target is cut to its low 32 bits. If either reserved status bit is set, the return does nothing except raise a one-cycle invalid-form exception pulse. All updates are synchronous. The redirect and exception outputs are registered, so they appear in the cycle after the request.

Top module: `ebb_ctrl_unit`

## Requirements
- R1: After synchronous active-low reset, all three registers read as zero and `redirect_valid` and `illegal_form` are low.
- R2: A write with `reg_wr_sel` 0 targets the status word, 1 the return word and 2 the handler word. `reg_rd_data` shows the selected word in the same cycle, and select 3 reads zero. Bits [1:0] of the return word always read zero.
- R3: An event is taken only when global enable (status bit 63) is 1 and the enable for its source is 1: bit 33 for the external source, bit 32 for the performance-monitor source. An event that is not taken has no effect.
- R4: One cycle after an event is taken, `redirect_valid` is 1, `redirect_pc` equals the handler word, and the global enable reads 0.
- R5: A taken event loads the return word with `next_pc` and forces bits [1:0] to zero.
- R6: A taken event sets the occurred bit of its source: bit 1 for external, bit 0 for performance-monitor. If both sources qualify in the same cycle, only the external one is taken.
- R7: A return with both reserved bits clear makes `redirect_valid` 1 one cycle later, with `redirect_pc` equal to the return word. It sets the global enable to `ret_set_ge`.
- R8: A return made while `mode64` is 0 has bits [63:32] of `redirect_pc` zero. The low 32 bits come from the return word.
- R9: A return made while status bit 31 or bit 30 is 1 pulses `illegal_form` for exactly one cycle. It makes no redirect and leaves the global enable unchanged.
- R10: A return request blocks any event in the same cycle. A register write in a cycle that has a return request or a taken event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 status, 1 return, 2 handler |
| reg_wr_data | input | 64 | Write data |
| reg_rd_sel | input | 2 | Read select, same encoding as the write select |
| reg_rd_data | output | 64 | Selected register value (combinational) |
| evt_ext_req | input | 1 | External event source request |
| evt_pm_req | input | 1 | Performance-monitor event source request |
| next_pc | input | 64 | Address of the instruction that would run next |
| mode64 | input | 1 | Core is in 64-bit mode |
| ret_req | input | 1 | Return-from-event-branch request |
| ret_set_ge | input | 1 | Return operand: new value of the global enable |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | 64 | Redirect target |
| illegal_form | output | 1 | Invalid-form exception pulse |

## Verification
The assertions check four behaviours on every cycle. A qualifying event or a clean return must redirect in the next cycle. The global enable must follow the return operand. Nothing may redirect while the enable is low. A return with reserved bits set must trap without touching the enable. Other behaviours need the bench's scenarios: the dropped-write and simultaneous-request priorities, the exact saved return address with its low bits forced to zero, the occurred-bit pattern when both sources fire together, and the 32-bit truncation of a wide return word.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

   // register select encoding on the access ports
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_RET  = 2'd1,
      SEL_HDL  = 2'd2,
      SEL_NONE = 2'd3
   } ebb_sel_e;

   // field positions, counted from the most significant bit as zero
   localparam int unsigned MB_GE      = 0;
   localparam int unsigned MB_EXT_EN  = 30;
   localparam int unsigned MB_PM_EN   = 31;
   localparam int unsigned MB_RSV_A   = 32;
   localparam int unsigned MB_RSV_B   = 33;
   localparam int unsigned MB_EXT_OCC = 62;
   localparam int unsigned MB_PM_OCC  = 63;

   // convert an MSB-zero position into a vector index
   function automatic int unsigned vec_idx(input int unsigned xlen, input int unsigned mb);
      return xlen - 1 - mb;
   endfunction

endpackage

// File: rtl/ebb_event_arb.sv
module ebb_event_arb #(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] stat_q,
   input  logic            ext_req,
   input  logic            pm_req,
   input  logic            block,
   output logic            take_ext,
   output logic            take_pm
);
   import ebb_pkg::*;

   localparam int unsigned GE_I  = vec_idx(XLEN, MB_GE);
   localparam int unsigned EXT_I = vec_idx(XLEN, MB_EXT_EN);
   localparam int unsigned PM_I  = vec_idx(XLEN, MB_PM_EN);

   logic ext_ok, pm_ok;

   always_comb begin
      ext_ok   = stat_q[GE_I] && stat_q[EXT_I] && ext_req && !block;
      pm_ok    = stat_q[GE_I] && stat_q[PM_I]  && pm_req  && !block;
      take_ext = ext_ok;
      take_pm  = pm_ok && !ext_ok;
   end

endmodule

// File: rtl/ebb_ret_unit.sv
module ebb_ret_unit #(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic            ret_req,
   input  logic            mode64,
   input  logic [XLEN-1:0] stat_q,
   input  logic [XLEN-1:0] ret_q,
   output logic            ret_ok,
   output logic            ret_bad,
   output logic [XLEN-1:0] ret_target
);
   import ebb_pkg::*;

   localparam int unsigned RSV_A_I = vec_idx(XLEN, MB_RSV_A);
   localparam int unsigned RSV_B_I = vec_idx(XLEN, MB_RSV_B);

   logic rsv_set;

   always_comb begin
      rsv_set = stat_q[RSV_A_I] | stat_q[RSV_B_I];
      ret_ok  = ret_req && !rsv_set;
      ret_bad = ret_req && rsv_set;
   end

   generate
      if (NARROW_W < XLEN) begin : g_trunc
         always_comb begin
            if (mode64) ret_target = ret_q;
            else        ret_target = {{(XLEN-NARROW_W){1'b0}}, ret_q[NARROW_W-1:0]};
         end
      end else begin : g_full
         always_comb ret_target = ret_q;
      end
   endgenerate

endmodule

// File: rtl/ebb_state_regs.sv
module ebb_state_regs #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned RET_ALIGN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [XLEN-1:0] wr_data,
   input  logic [1:0]      rd_sel,
   output logic [XLEN-1:0] rd_data,
   input  logic            ret_req,
   input  logic            take_ext,
   input  logic            take_pm,
   input  logic            ret_ok,
   input  logic            ret_set_ge,
   input  logic [XLEN-1:0] next_pc,
   output logic [XLEN-1:0] stat_q,
   output logic [XLEN-1:0] ret_q,
   output logic [XLEN-1:0] hdl_q
);
   import ebb_pkg::*;

   localparam int unsigned GE_I   = vec_idx(XLEN, MB_GE);
   localparam int unsigned EOCC_I = vec_idx(XLEN, MB_EXT_OCC);
   localparam int unsigned POCC_I = vec_idx(XLEN, MB_PM_OCC);
   localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-RET_ALIGN){1'b1}}, {RET_ALIGN{1'b0}}};

   logic take, wr_ok;

   always_comb begin
      take  = take_ext | take_pm;
      wr_ok = wr_en && !ret_req && !take;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         ret_q  <= '0;
         hdl_q  <= '0;
      end else if (take) begin
         stat_q[GE_I] <= 1'b0;
         if (take_ext) stat_q[EOCC_I] <= 1'b1;
         if (take_pm)  stat_q[POCC_I] <= 1'b1;
         ret_q <= next_pc & ALIGN_MASK;
      end else if (ret_ok) begin
         stat_q[GE_I] <= ret_set_ge;
      end else if (wr_ok) begin
         case (ebb_sel_e'(wr_sel))
            SEL_STAT: stat_q <= wr_data;
            SEL_RET:  ret_q  <= wr_data & ALIGN_MASK;
            SEL_HDL:  hdl_q  <= wr_data;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (ebb_sel_e'(rd_sel))
         SEL_STAT: rd_data = stat_q;
         SEL_RET:  rd_data = ret_q;
         SEL_HDL:  rd_data = hdl_q;
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/ebb_ctrl_unit.sv
module ebb_ctrl_unit #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned NARROW_W  = 32,
   parameter int unsigned RET_ALIGN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr_en,
   input  logic [1:0]      reg_wr_sel,
   input  logic [XLEN-1:0] reg_wr_data,
   input  logic [1:0]      reg_rd_sel,
   output logic [XLEN-1:0] reg_rd_data,
   input  logic            evt_ext_req,
   input  logic            evt_pm_req,
   input  logic [XLEN-1:0] next_pc,
   input  logic            mode64,
   input  logic            ret_req,
   input  logic            ret_set_ge,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   output logic            illegal_form
);
   import ebb_pkg::*;

   localparam int unsigned GE_I   = vec_idx(XLEN, MB_GE);
   localparam int unsigned EEN_I  = vec_idx(XLEN, MB_EXT_EN);
   localparam int unsigned PEN_I  = vec_idx(XLEN, MB_PM_EN);
   localparam int unsigned RA_I   = vec_idx(XLEN, MB_RSV_A);
   localparam int unsigned RB_I   = vec_idx(XLEN, MB_RSV_B);
   localparam int unsigned EOCC_I = vec_idx(XLEN, MB_EXT_OCC);
   localparam int unsigned POCC_I = vec_idx(XLEN, MB_PM_OCC);

   generate
      if (XLEN < 64) begin : g_bad_xlen
         $error("ebb_ctrl_unit: XLEN must be at least 64");
      end
      if (NARROW_W == 0 || NARROW_W > XLEN) begin : g_bad_narrow
         $error("ebb_ctrl_unit: NARROW_W out of range");
      end
      if (RET_ALIGN == 0 || RET_ALIGN >= XLEN) begin : g_bad_align
         $error("ebb_ctrl_unit: RET_ALIGN out of range");
      end
   endgenerate

   logic [XLEN-1:0] stat_q, ret_q, hdl_q, ret_target;
   logic            take_ext, take_pm, ret_ok, ret_bad;

   ebb_event_arb #(.XLEN(XLEN)) u_arb (
      .stat_q   (stat_q),
      .ext_req  (evt_ext_req),
      .pm_req   (evt_pm_req),
      .block    (ret_req),
      .take_ext (take_ext),
      .take_pm  (take_pm)
   );

   ebb_ret_unit #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_ret (
      .ret_req    (ret_req),
      .mode64     (mode64),
      .stat_q     (stat_q),
      .ret_q      (ret_q),
      .ret_ok     (ret_ok),
      .ret_bad    (ret_bad),
      .ret_target (ret_target)
   );

   ebb_state_regs #(.XLEN(XLEN), .RET_ALIGN(RET_ALIGN)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .wr_sel     (reg_wr_sel),
      .wr_data    (reg_wr_data),
      .rd_sel     (reg_rd_sel),
      .rd_data    (reg_rd_data),
      .ret_req    (ret_req),
      .take_ext   (take_ext),
      .take_pm    (take_pm),
      .ret_ok     (ret_ok),
      .ret_set_ge (ret_set_ge),
      .next_pc    (next_pc),
      .stat_q     (stat_q),
      .ret_q      (ret_q),
      .hdl_q      (hdl_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
         illegal_form   <= 1'b0;
      end else begin
         redirect_valid <= take_ext | take_pm | ret_ok;
         illegal_form   <= ret_bad;
         if (take_ext | take_pm) redirect_pc <= hdl_q;
         else if (ret_ok)        redirect_pc <= ret_target;
      end
   end

   // qualifying external event redirects to the handler and drops the enable
   assert_evt_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ext_req && !ret_req && stat_q[GE_I] && stat_q[EEN_I])
      |=> (redirect_valid && redirect_pc == $past(hdl_q) && !stat_q[GE_I]));

   // with the enable low and no return, nothing redirects
   assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[GE_I] && !ret_req) |=> !redirect_valid);

   // both sources qualify: only the external occurred flag moves
   assert_ext_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ext_req && evt_pm_req && !ret_req && stat_q[GE_I] && stat_q[EEN_I]
       && stat_q[PEN_I] && !stat_q[POCC_I])
      |=> (stat_q[EOCC_I] && !stat_q[POCC_I]));

   // clean return: redirect and enable follows the operand
   assert_ret_ge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !stat_q[RA_I] && !stat_q[RB_I])
      |=> (redirect_valid && stat_q[GE_I] == $past(ret_set_ge)));

   // reserved bits set: trap, no redirect, enable untouched
   assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && (stat_q[RA_I] || stat_q[RB_I]))
      |=> (illegal_form && !redirect_valid && stat_q[GE_I] == $past(stat_q[GE_I])));

   generate
      if (NARROW_W < XLEN) begin : g_trunc_chk
         // narrow mode return leaves the upper target bits zero
         assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_req && !mode64 && !stat_q[RA_I] && !stat_q[RB_I])
            |=> (redirect_pc[XLEN-1:NARROW_W] == '0));
      end
   endgenerate

endmodule

// File: tb/ebb_ctrl_unit_tb.sv
module ebb_ctrl_unit_tb;

   typedef struct {
      logic        v;
      logic [63:0] pc;
      logic        ill;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_wr_sel = 2'd0;
   logic [63:0] reg_wr_data = '0;
   logic [1:0]  reg_rd_sel = 2'd0;
   logic [63:0] reg_rd_data;
   logic        evt_ext_req = 1'b0;
   logic        evt_pm_req = 1'b0;
   logic [63:0] next_pc = '0;
   logic        mode64 = 1'b1;
   logic        ret_req = 1'b0;
   logic        ret_set_ge = 1'b0;
   logic        redirect_valid;
   logic [63:0] redirect_pc;
   logic        illegal_form;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   exp_t sb[$];

   // bench model of the three registers
   logic [63:0] m_stat = '0, m_ret = '0, m_hdl = '0;

   always #10 clk = ~clk;

   ebb_ctrl_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .evt_ext_req(evt_ext_req), .evt_pm_req(evt_pm_req), .next_pc(next_pc),
      .mode64(mode64), .ret_req(ret_req), .ret_set_ge(ret_set_ge),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .illegal_form(illegal_form)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: one posedge after each driven step, compare with the front item
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(redirect_valid === e.v, e.tag, "redirect_valid", 64'(redirect_valid), 64'(e.v));
            chk(illegal_form === e.ill, e.tag, "illegal_form", 64'(illegal_form), 64'(e.ill));
            if (e.v) chk(redirect_pc === e.pc, e.tag, "redirect_pc", redirect_pc, e.pc);
         end
      end
   end

   // driver: one cycle of stimulus, expected outcome from the model
   task automatic step(input logic wen, input logic [1:0] wsel, input logic [63:0] wdata,
                       input logic ext, input logic pm, input logic [63:0] npc,
                       input logic m64, input logic ret, input logic s, input string tag);
      exp_t e;
      bit ge;
      @(negedge clk);
      reg_wr_en = wen; reg_wr_sel = wsel; reg_wr_data = wdata;
      evt_ext_req = ext; evt_pm_req = pm; next_pc = npc;
      mode64 = m64; ret_req = ret; ret_set_ge = s;
      e.v = 1'b0; e.pc = '0; e.ill = 1'b0; e.tag = tag;
      ge = m_stat[63];
      if (ret) begin
         if (m_stat[31] || m_stat[30]) e.ill = 1'b1;
         else begin
            e.v = 1'b1;
            e.pc = m64 ? m_ret : {32'd0, m_ret[31:0]};
            m_stat[63] = s;
         end
      end else if (ge && ext && m_stat[33]) begin
         e.v = 1'b1; e.pc = m_hdl;
         m_stat[63] = 1'b0; m_stat[1] = 1'b1;
         m_ret = {npc[63:2], 2'b00};
      end else if (ge && pm && m_stat[32]) begin
         e.v = 1'b1; e.pc = m_hdl;
         m_stat[63] = 1'b0; m_stat[0] = 1'b1;
         m_ret = {npc[63:2], 2'b00};
      end else if (wen) begin
         case (wsel)
            2'd0: m_stat = wdata;
            2'd1: m_ret = {wdata[63:2], 2'b00};
            2'd2: m_hdl = wdata;
            default: ;
         endcase
      end
      sb.push_back(e);
      @(posedge clk);
      #1;
      reg_wr_en = 1'b0; evt_ext_req = 1'b0; evt_pm_req = 1'b0;
      ret_req = 1'b0; ret_set_ge = 1'b0; mode64 = 1'b1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [63:0] d, input string tag);
      step(1'b1, sel, d, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, tag);
   endtask

   task automatic rd(input logic [1:0] sel, input logic [63:0] exp, input string tag);
      reg_rd_sel = sel;
      #1;
      chk(reg_rd_data === exp, tag, $sformatf("read sel %0d", sel), reg_rd_data, exp);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, tag);
   endtask

   initial begin
      #(20 * 5000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk(redirect_valid === 1'b0, "R1", "redirect_valid", 64'(redirect_valid), 64'd0);
      chk(illegal_form === 1'b0, "R1", "illegal_form", 64'(illegal_form), 64'd0);
      rd(2'd0, '0, "R1"); rd(2'd1, '0, "R1"); rd(2'd2, '0, "R1");

      // R2 register access, low return bits forced to zero, select 3 reads zero
      wr(2'd1, 64'h0123_4567_89AB_CDEF, "R2");
      rd(2'd1, 64'h0123_4567_89AB_CDEC, "R2");
      wr(2'd2, 64'hFFFF_0000_0000_1000, "R2");
      rd(2'd2, 64'hFFFF_0000_0000_1000, "R2");
      wr(2'd0, 64'h8000_0003_0000_0000, "R2");
      rd(2'd0, 64'h8000_0003_0000_0000, "R2");
      rd(2'd3, '0, "R2");

      // R4 R5 R6 external event taken
      step(1'b0, 2'd0, '0, 1'b1, 1'b0, 64'h0000_1234_5678_9ABF, 1'b1, 1'b0, 1'b0, "R4");
      rd(2'd1, 64'h0000_1234_5678_9ABC, "R5");
      rd(2'd0, 64'h0000_0003_0000_0002, "R6");

      // R3 event with global enable low is ignored
      step(1'b0, 2'd0, '0, 1'b1, 1'b1, 64'h0000_0000_0000_4440, 1'b1, 1'b0, 1'b0, "R3");
      rd(2'd1, 64'h0000_1234_5678_9ABC, "R3");
      rd(2'd0, 64'h0000_0003_0000_0002, "R3");

      // R7 return in 64-bit mode sets the enable
      step(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, "R7");
      rd(2'd0, 64'h8000_0003_0000_0002, "R7");

      // R3 source enable off: external ignored, monitor source taken
      wr(2'd0, 64'h8000_0001_0000_0000, "R3");
      step(1'b0, 2'd0, '0, 1'b1, 1'b1, 64'hAAAA_BBBB_CCCC_DDD0, 1'b1, 1'b0, 1'b0, "R3");
      rd(2'd0, 64'h0000_0001_0000_0001, "R6");

      // R6 both qualify: external wins
      wr(2'd0, 64'h8000_0003_0000_0000, "R6");
      step(1'b0, 2'd0, '0, 1'b1, 1'b1, 64'hAAAA_BBBB_CCCC_DDD6, 1'b1, 1'b0, 1'b0, "R6");
      rd(2'd0, 64'h0000_0003_0000_0002, "R6");
      rd(2'd1, 64'hAAAA_BBBB_CCCC_DDD4, "R5");

      // R8 R10 narrow return clearing the enable, concurrent write dropped
      step(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R8");
      rd(2'd0, 64'h0000_0003_0000_0002, "R10");

      // R10 return blocks a same-cycle event
      wr(2'd0, 64'h8000_0003_0000_0000, "R10");
      step(1'b0, 2'd0, '0, 1'b1, 1'b0, 64'h0000_0000_0000_7770, 1'b1, 1'b1, 1'b1, "R10");
      rd(2'd1, 64'hAAAA_BBBB_CCCC_DDD4, "R10");
      rd(2'd0, 64'h8000_0003_0000_0000, "R10");

      // R10 write dropped during a taken event
      step(1'b1, 2'd2, 64'h1111_1111_1111_1111, 1'b1, 1'b0, 64'h0000_0000_0000_9990, 1'b1, 1'b0, 1'b0, "R10");
      rd(2'd2, 64'hFFFF_0000_0000_1000, "R10");

      // R9 reserved bit set: trap pulse, enable kept, then pulse gone
      wr(2'd0, 64'h8000_0003_8000_0000, "R9");
      step(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R9");
      rd(2'd0, 64'h8000_0003_8000_0000, "R9");
      idle("R9");
      wr(2'd0, 64'h0000_0000_4000_0000, "R9");
      step(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, "R9");
      rd(2'd0, 64'h0000_0000_4000_0000, "R9");
      idle("R9");

      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule